// File: doc/BRIEF.md
# Byte Stack and Subroutine Sequencer

This block keeps an 8-bit stack pointer into one fixed 256-byte page of memory. It turns six stack commands into byte accesses on a single-port memory, one access per clock. The commands are: save the accumulator, save the status byte, restore either of them, enter a subroutine and leave a subroutine. The stack grows downward. A save writes at the pointer and then moves it down. A restore moves the pointer up first and then reads.

A subroutine entry stores the program counter minus one as two bytes, high byte first, and hands back the target address as the next program counter. A subroutine exit reads the two bytes back, low byte first. It adds one to the 16-bit value, wrapping modulo 65536, and hands the result back as the next program counter. Each finished command reports, on a one-cycle `done` pulse, the number of extra cycles the instruction costs. Restores also return the byte that was read.

Top module: `callstack_unit`

## Requirements
- R1: After reset `sp` equals the parameter `SP_RESET` (0xFD by default), and `busy`, `done`, `pc_load`, `pull_valid`, `mem_we` and `mem_re` are all low.
- R2: A command is taken when `cmd_valid` is high while `busy` is low. Opcode 0 saves `acc_in` and opcode 1 saves `stat_in`. In the cycle after acceptance the block writes the byte at address `{STACK_PAGE, sp}`, and `sp` then drops by one. `done` pulses one cycle later with `extra_cycles` = 1.
- R3: Opcode 2 restores to the accumulator and opcode 3 restores to the status byte. In the cycle after acceptance `mem_re` is high at `{STACK_PAGE, sp+1}`, and `sp` rises by one. Memory data is sampled one cycle after `mem_re`. `done` and `pull_valid` then pulse together, carrying the read byte on `pull_data` and `pull_to_status` = 1 only for opcode 3, with `extra_cycles` = 1.
- R4: Opcode 4 (call) writes the high byte of `pc_in`−1 at `{STACK_PAGE, sp}`, then the low byte at `{STACK_PAGE, sp−1}`. It ends with `sp` lowered by two, `pc_next` = `target_in`, and `pc_load` and `done` pulsing together with `extra_cycles` = 2.
- R5: Opcode 5 (return) reads the low byte at `{STACK_PAGE, sp+1}` and the high byte at `{STACK_PAGE, sp+2}` on two consecutive cycles. It ends with `sp` raised by two, `pc_next` = (high·256 + low + 1) mod 65536, and `pc_load` and `done` pulsing together with `extra_cycles` = 4.
- R6: `sp` wraps modulo 256 in both directions without any flag, and every stack address stays inside page `STACK_PAGE`.
- R7: Commands presented while `busy` is high are ignored, and opcodes 6 and 7 are ignored. Neither causes a memory access, a `done` pulse or a change of `sp`.
- R8: At most one of `mem_we` and `mem_re` is high in any cycle, and either is high only while `busy` is high. `busy` falls only in the cycle where `done` pulses.
- R9: A call followed by a return hands back the call's `pc_in`, including `pc_in` = 0x0000, whose stored value is 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code (0..5 used) |
| acc_in | input | DW | Accumulator byte to save |
| stat_in | input | DW | Status byte to save |
| pc_in | input | 2*DW | Current program counter |
| target_in | input | 2*DW | Subroutine entry address |
| mem_addr | output | 2*DW | Stack memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe (data one cycle later) |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| busy | output | 1 | Command sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_load | output | 1 | `pc_next` is to be loaded (call/return) |
| pc_next | output | 2*DW | Next program counter |
| pull_valid | output | 1 | `pull_data` holds a restored byte |
| pull_data | output | DW | Byte read by a restore |
| pull_to_status | output | 1 | Restored byte belongs to the status byte |
| extra_cycles | output | 3 | Extra cycle cost of the finished command |
| sp | output | DW | Current stack pointer |

## Verification
The bench keeps the default 8-bit data width and page 0x01, but sets `SP_RESET` to 0x03. With that value a handful of saves carry the pointer through 0x00 to 0xFF. Wrap-around on saves, restores, calls and returns can then all be reached within a short run. A call made with the pointer at 0x00 splits its two bytes across both ends of the page. The return that follows reads them back across the same boundary.

// File: rtl/callstack_pkg.sv
`timescale 1ns/1ps
package callstack_pkg;

    // command codes seen on cmd_op
    localparam logic [2:0] OPC_PUSH_ACC  = 3'd0;
    localparam logic [2:0] OPC_PUSH_STAT = 3'd1;
    localparam logic [2:0] OPC_PULL_ACC  = 3'd2;
    localparam logic [2:0] OPC_PULL_STAT = 3'd3;
    localparam logic [2:0] OPC_CALL      = 3'd4;
    localparam logic [2:0] OPC_RETURN    = 3'd5;

    // extra cycle costs
    localparam int         XC_W     = 3;
    localparam logic [2:0] XC_STACK = 3'd1;
    localparam logic [2:0] XC_CALL  = 3'd2;
    localparam logic [2:0] XC_RET   = 3'd4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH,
        ST_PULL_ADR,
        ST_PULL_CAP,
        ST_CALL_HI,
        ST_CALL_LO,
        ST_RET_LO,
        ST_RET_HI,
        ST_RET_FIN
    } seq_state_e;

endpackage

// File: rtl/cs_addr_gen.sv
`timescale 1ns/1ps
// Forms the stack memory address: fixed page, offset = sp or sp+1.
module cs_addr_gen #(
    parameter int            DW         = 8,
    parameter logic [DW-1:0] STACK_PAGE = 'h01,
    localparam int           AW         = 2 * DW
) (
    input  logic [DW-1:0] sp,
    input  logic          sel_inc,
    output logic [AW-1:0] addr
);
    localparam logic [DW-1:0] STEP = {{(DW-1){1'b0}}, 1'b1};

    logic [DW-1:0] offset;

    always_comb begin
        offset = sel_inc ? (sp + STEP) : sp;
        addr   = {STACK_PAGE, offset};
    end
endmodule

// File: rtl/cs_pc_arith.sv
`timescale 1ns/1ps
// Return-address arithmetic: PC-1 for a call, {hi,lo}+1 for a return.
module cs_pc_arith #(
    parameter int  DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] lo_byte,
    input  logic [DW-1:0] hi_byte,
    output logic [AW-1:0] pc_dec,
    output logic [AW-1:0] ret_pc
);
    localparam logic [AW-1:0] PC_ONE = {{(AW-1){1'b0}}, 1'b1};

    always_comb begin
        pc_dec = pc_in - PC_ONE;
        ret_pc = {hi_byte, lo_byte} + PC_ONE;
    end
endmodule

// File: rtl/cs_seq.sv
`timescale 1ns/1ps
// Command sequencer: one memory access per clock, all state in one struct.
module cs_seq
    import callstack_pkg::*;
#(
    parameter int            DW       = 8,
    parameter logic [DW-1:0] SP_RESET = 'hFD,
    localparam int           AW       = 2 * DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [DW-1:0]   acc_in,
    input  logic [DW-1:0]   stat_in,
    input  logic [AW-1:0]   pc_dec,
    input  logic [AW-1:0]   target_in,
    input  logic [DW-1:0]   rd_byte,
    input  logic [AW-1:0]   ret_pc,
    output logic [DW-1:0]   sp,
    output logic            addr_inc,
    output logic            wr_en,
    output logic            rd_en,
    output logic [DW-1:0]   wr_byte,
    output logic [DW-1:0]   lo_byte,
    output logic            busy,
    output logic            done,
    output logic            pc_load,
    output logic [AW-1:0]   pc_next,
    output logic            pull_valid,
    output logic [DW-1:0]   pull_data,
    output logic            pull_to_status,
    output logic [XC_W-1:0] extra
);
    localparam logic [DW-1:0] STEP = {{(DW-1){1'b0}}, 1'b1};

    typedef struct packed {
        seq_state_e      st;
        logic [DW-1:0]   sp;
        logic [DW-1:0]   hold;
        logic [DW-1:0]   lo;
        logic [AW-1:0]   tgt;
        logic            done;
        logic            pc_load;
        logic [AW-1:0]   pc_next;
        logic            pull_valid;
        logic [DW-1:0]   pull_data;
        logic            to_stat;
        logic [XC_W-1:0] extra;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      we_c, re_c, inc_c;
    logic [DW-1:0] wd_c;

    always_comb begin
        r_d            = r_q;
        r_d.done       = 1'b0;
        r_d.pc_load    = 1'b0;
        r_d.pull_valid = 1'b0;
        we_c           = 1'b0;
        re_c           = 1'b0;
        inc_c          = 1'b0;
        wd_c           = r_q.hold;

        case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    case (cmd_op)
                        OPC_PUSH_ACC: begin
                            r_d.hold = acc_in;
                            r_d.st   = ST_PUSH;
                        end
                        OPC_PUSH_STAT: begin
                            r_d.hold = stat_in;
                            r_d.st   = ST_PUSH;
                        end
                        OPC_PULL_ACC: begin
                            r_d.to_stat = 1'b0;
                            r_d.st      = ST_PULL_ADR;
                        end
                        OPC_PULL_STAT: begin
                            r_d.to_stat = 1'b1;
                            r_d.st      = ST_PULL_ADR;
                        end
                        OPC_CALL: begin
                            r_d.hold = pc_dec[AW-1:DW];
                            r_d.lo   = pc_dec[DW-1:0];
                            r_d.tgt  = target_in;
                            r_d.st   = ST_CALL_HI;
                        end
                        OPC_RETURN: begin
                            r_d.st = ST_RET_LO;
                        end
                        default: ;
                    endcase
                end
            end
            ST_PUSH: begin
                we_c      = 1'b1;
                r_d.sp    = r_q.sp - STEP;
                r_d.done  = 1'b1;
                r_d.extra = XC_STACK;
                r_d.st    = ST_IDLE;
            end
            ST_PULL_ADR: begin
                re_c   = 1'b1;
                inc_c  = 1'b1;
                r_d.sp = r_q.sp + STEP;
                r_d.st = ST_PULL_CAP;
            end
            ST_PULL_CAP: begin
                r_d.pull_data  = rd_byte;
                r_d.pull_valid = 1'b1;
                r_d.done       = 1'b1;
                r_d.extra      = XC_STACK;
                r_d.st         = ST_IDLE;
            end
            ST_CALL_HI: begin
                we_c   = 1'b1;
                r_d.sp = r_q.sp - STEP;
                r_d.st = ST_CALL_LO;
            end
            ST_CALL_LO: begin
                we_c        = 1'b1;
                wd_c        = r_q.lo;
                r_d.sp      = r_q.sp - STEP;
                r_d.pc_next = r_q.tgt;
                r_d.pc_load = 1'b1;
                r_d.done    = 1'b1;
                r_d.extra   = XC_CALL;
                r_d.st      = ST_IDLE;
            end
            ST_RET_LO: begin
                re_c   = 1'b1;
                inc_c  = 1'b1;
                r_d.sp = r_q.sp + STEP;
                r_d.st = ST_RET_HI;
            end
            ST_RET_HI: begin
                re_c   = 1'b1;
                inc_c  = 1'b1;
                r_d.sp = r_q.sp + STEP;
                r_d.lo = rd_byte;
                r_d.st = ST_RET_FIN;
            end
            ST_RET_FIN: begin
                r_d.pc_next = ret_pc;
                r_d.pc_load = 1'b1;
                r_d.done    = 1'b1;
                r_d.extra   = XC_RET;
                r_d.st      = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
            r_q.sp <= SP_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign sp             = r_q.sp;
    assign addr_inc       = inc_c;
    assign wr_en          = we_c;
    assign rd_en          = re_c;
    assign wr_byte        = wd_c;
    assign lo_byte        = r_q.lo;
    assign busy           = (r_q.st != ST_IDLE);
    assign done           = r_q.done;
    assign pc_load        = r_q.pc_load;
    assign pc_next        = r_q.pc_next;
    assign pull_valid     = r_q.pull_valid;
    assign pull_data      = r_q.pull_data;
    assign pull_to_status = r_q.to_stat;
    assign extra          = r_q.extra;
endmodule

// File: rtl/callstack_unit.sv
`timescale 1ns/1ps
module callstack_unit
    import callstack_pkg::*;
#(
    parameter int            DW         = 8,
    parameter logic [DW-1:0] STACK_PAGE = 'h01,
    parameter logic [DW-1:0] SP_RESET   = 'hFD,
    localparam int           AW         = 2 * DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [DW-1:0]   acc_in,
    input  logic [DW-1:0]   stat_in,
    input  logic [AW-1:0]   pc_in,
    input  logic [AW-1:0]   target_in,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_we,
    output logic            mem_re,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic            busy,
    output logic            done,
    output logic            pc_load,
    output logic [AW-1:0]   pc_next,
    output logic            pull_valid,
    output logic [DW-1:0]   pull_data,
    output logic            pull_to_status,
    output logic [XC_W-1:0] extra_cycles,
    output logic [DW-1:0]   sp
);
    logic [AW-1:0] pc_dec_w;
    logic [AW-1:0] ret_pc_w;
    logic [DW-1:0] lo_w;
    logic          inc_w;

    cs_pc_arith #(.DW(DW)) u_arith (
        .pc_in   (pc_in),
        .lo_byte (lo_w),
        .hi_byte (mem_rdata),
        .pc_dec  (pc_dec_w),
        .ret_pc  (ret_pc_w)
    );

    cs_seq #(.DW(DW), .SP_RESET(SP_RESET)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_op         (cmd_op),
        .acc_in         (acc_in),
        .stat_in        (stat_in),
        .pc_dec         (pc_dec_w),
        .target_in      (target_in),
        .rd_byte        (mem_rdata),
        .ret_pc         (ret_pc_w),
        .sp             (sp),
        .addr_inc       (inc_w),
        .wr_en          (mem_we),
        .rd_en          (mem_re),
        .wr_byte        (mem_wdata),
        .lo_byte        (lo_w),
        .busy           (busy),
        .done           (done),
        .pc_load        (pc_load),
        .pc_next        (pc_next),
        .pull_valid     (pull_valid),
        .pull_data      (pull_data),
        .pull_to_status (pull_to_status),
        .extra          (extra_cycles)
    );

    cs_addr_gen #(.DW(DW), .STACK_PAGE(STACK_PAGE)) u_addr (
        .sp      (sp),
        .sel_inc (inc_w),
        .addr    (mem_addr)
    );
endmodule

// File: rtl/callstack_unit_chk.sv
`timescale 1ns/1ps
module callstack_unit_chk #(
    parameter int            DW         = 8,
    parameter logic [DW-1:0] STACK_PAGE = 'h01,
    localparam int           AW         = 2 * DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          pc_load,
    input logic          pull_valid,
    input logic          mem_we,
    input logic          mem_re,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] sp
);
    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    a_r8_strobe_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> busy);

    a_r8_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r6_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (mem_addr[AW-1:DW] == STACK_PAGE));

    a_r2_write_lowers_sp: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp == $past(sp) - ONE));

    a_r3_read_raises_sp: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (sp == $past(sp) + ONE));

    a_r3_pull_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        pull_valid |-> done);

    a_r4_load_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (done && !busy));

    a_r7_idle_sp_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && !done) |-> $stable(sp));
endmodule

bind callstack_unit callstack_unit_chk #(.DW(DW), .STACK_PAGE(STACK_PAGE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .pc_load    (pc_load),
    .pull_valid (pull_valid),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .mem_addr   (mem_addr),
    .sp         (sp)
);

// File: tb/callstack_unit_bench.sv
`timescale 1ns/1ps
module callstack_unit_bench;
    localparam logic [7:0] PAGE = 8'h01;
    localparam logic [7:0] SPR  = 8'h03;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [7:0]  acc_in = 8'h00;
    logic [7:0]  stat_in = 8'h00;
    logic [15:0] pc_in = 16'h0000;
    logic [15:0] target_in = 16'h0000;
    logic [15:0] mem_addr;
    logic        mem_we, mem_re;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        busy, done, pc_load, pull_valid, pull_to_status;
    logic [15:0] pc_next;
    logic [7:0]  pull_data, sp;
    logic [2:0]  extra_cycles;

    int checks = 0;
    int fails  = 0;
    int exp_sp;
    logic [7:0] bmem    [256];
    logic [7:0] ref_mem [256];

    always #2.5 clk = ~clk;

    callstack_unit #(.DW(8), .STACK_PAGE(PAGE), .SP_RESET(SPR)) u_callstack_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .acc_in(acc_in), .stat_in(stat_in), .pc_in(pc_in), .target_in(target_in),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .pc_load(pc_load),
        .pc_next(pc_next), .pull_valid(pull_valid), .pull_data(pull_data),
        .pull_to_status(pull_to_status), .extra_cycles(extra_cycles), .sp(sp)
    );

    // bench-side stack memory, one-cycle read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bmem[i] <= 8'h00;
        end else begin
            if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
            if (mem_re) mem_rdata <= bmem[mem_addr[7:0]];
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    // quiet cycles: no strobes, no done, sp unchanged
    task automatic idle_check(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(req, "busy idle", busy, 0);
            chk(req, "done idle", done, 0);
            chk(req, "strobes idle", {mem_we, mem_re}, 0);
            chk(req, "sp idle", sp, exp_sp);
        end
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [7:0] a, input logic [7:0] p,
                          input logic [15:0] pc, input logic [15:0] tgt,
                          input bit hold, input string req);
        int lat;
        int s0;
        int pcm1;
        int ew, er, ea, ed;
        int bad;
        s0   = exp_sp;
        pcm1 = (int'(pc) - 1) & 16'hFFFF;
        case (op)
            3'd0, 3'd1: lat = 1;
            3'd2, 3'd3: lat = 2;
            3'd4:       lat = 2;
            default:    lat = 3;
        endcase
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; acc_in = a; stat_in = p;
        pc_in = pc; target_in = tgt;
        @(negedge clk);
        if (!hold) cmd_valid = 1'b0;
        for (int k = 1; k <= lat; k++) begin
            ew = 0; er = 0; ea = 0; ed = 0;
            case (op)
                3'd0, 3'd1: if (k == 1) begin ew = 1; ea = s0; ed = (op == 3'd0) ? a : p; end
                3'd2, 3'd3: if (k == 1) begin er = 1; ea = (s0 + 1) & 255; end
                3'd4: begin
                    ew = 1;
                    ea = (k == 1) ? s0 : ((s0 - 1) & 255);
                    ed = (k == 1) ? (pcm1 >> 8) : (pcm1 & 255);
                end
                default: begin
                    if (k == 1) begin er = 1; ea = (s0 + 1) & 255; end
                    if (k == 2) begin er = 1; ea = (s0 + 2) & 255; end
                end
            endcase
            chk("R8", "busy during sequence", busy, 1);
            chk("R8", "done during sequence", done, 0);
            chk(req, "mem_we", mem_we, ew);
            chk(req, "mem_re", mem_re, er);
            if (ew != 0 || er != 0) chk("R6", "mem_addr", mem_addr, {PAGE, 8'(ea)});
            if (ew != 0) chk(req, "mem_wdata", mem_wdata, ed);
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk(req, "done pulse", done, 1);
        chk("R8", "busy after sequence", busy, 0);
        case (op)
            3'd0, 3'd1: begin
                ref_mem[s0] = (op == 3'd0) ? a : p;
                exp_sp = (s0 - 1) & 255;
                chk(req, "extra_cycles", extra_cycles, 1);
            end
            3'd2, 3'd3: begin
                exp_sp = (s0 + 1) & 255;
                chk(req, "pull_valid", pull_valid, 1);
                chk(req, "pull_data", pull_data, ref_mem[exp_sp]);
                chk(req, "pull_to_status", pull_to_status, (op == 3'd3) ? 1 : 0);
                chk(req, "extra_cycles", extra_cycles, 1);
            end
            3'd4: begin
                ref_mem[s0] = 8'(pcm1 >> 8);
                ref_mem[(s0 - 1) & 255] = 8'(pcm1);
                exp_sp = (s0 - 2) & 255;
                chk(req, "pc_load", pc_load, 1);
                chk(req, "pc_next", pc_next, tgt);
                chk(req, "extra_cycles", extra_cycles, 2);
            end
            default: begin
                chk(req, "pc_load", pc_load, 1);
                chk(req, "pc_next", pc_next,
                    (ref_mem[(s0 + 1) & 255] + 256 * ref_mem[(s0 + 2) & 255] + 1) & 16'hFFFF);
                exp_sp = (s0 + 2) & 255;
                chk(req, "extra_cycles", extra_cycles, 4);
            end
        endcase
        chk(req, "sp after command", sp, exp_sp);
        bad = 0;
        for (int i = 0; i < 256; i++) if (bmem[i] !== ref_mem[i]) bad++;
        chk(req, "stack memory mismatches", bad, 0);
        @(negedge clk);
        chk(req, "done is a single pulse", done, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
        exp_sp = SPR;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "sp reset", sp, SPR);
        chk("R1", "busy reset", busy, 0);
        chk("R1", "outputs reset", {done, pc_load, pull_valid, mem_we, mem_re}, 0);
        rst_n = 1'b1;
        idle_check(2, "R1");

        // R2 saves, R3 restores
        do_cmd(3'd0, 8'h5A, 8'h00, 16'h0, 16'h0, 1'b0, "R2");
        do_cmd(3'd1, 8'h00, 8'hC3, 16'h0, 16'h0, 1'b0, "R2");
        do_cmd(3'd2, 8'h00, 8'h00, 16'h0, 16'h0, 1'b0, "R3");
        do_cmd(3'd3, 8'h00, 8'h00, 16'h0, 16'h0, 1'b0, "R3");

        // R6 wrap downward then upward
        do_cmd(3'd0, 8'h11, 8'h00, 16'h0, 16'h0, 1'b0, "R2");
        do_cmd(3'd0, 8'h22, 8'h00, 16'h0, 16'h0, 1'b0, "R2");
        do_cmd(3'd1, 8'h00, 8'h33, 16'h0, 16'h0, 1'b0, "R2");
        do_cmd(3'd0, 8'h44, 8'h00, 16'h0, 16'h0, 1'b0, "R6");
        chk("R6", "sp wrapped to 0xFF", sp, 8'hFF);
        do_cmd(3'd2, 8'h00, 8'h00, 16'h0, 16'h0, 1'b0, "R6");
        chk("R6", "sp wrapped to 0x00", sp, 8'h00);

        // R4 call across page ends, R9 round trip
        do_cmd(3'd4, 8'h00, 8'h00, 16'h1234, 16'hABCD, 1'b0, "R4");
        do_cmd(3'd5, 8'h00, 8'h00, 16'h0, 16'h0, 1'b0, "R5");
        chk("R9", "round trip pc", pc_next, 16'h1234);

        do_cmd(3'd4, 8'h00, 8'h00, 16'h0000, 16'h8000, 1'b0, "R4");
        do_cmd(3'd5, 8'h00, 8'h00, 16'h0, 16'h0, 1'b0, "R9");
        chk("R9", "round trip of pc 0x0000", pc_next, 16'h0000);

        // R5 return of a hand-built address: hi 0x7F, lo 0xFF -> 0x8000
        do_cmd(3'd0, 8'h7F, 8'h00, 16'h0, 16'h0, 1'b0, "R5");
        do_cmd(3'd0, 8'hFF, 8'h00, 16'h0, 16'h0, 1'b0, "R5");
        do_cmd(3'd5, 8'h00, 8'h00, 16'h0, 16'h0, 1'b0, "R5");
        chk("R5", "carry into high byte", pc_next, 16'h8000);

        // R7 request held through busy is taken once
        do_cmd(3'd4, 8'h00, 8'h00, 16'h4000, 16'h2000, 1'b1, "R7");
        idle_check(3, "R7");

        // R7 unused opcodes
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd6;
        @(negedge clk);
        chk("R7", "opcode 6 ignored", {busy, mem_we, mem_re}, 0);
        cmd_op = 3'd7;
        @(negedge clk);
        chk("R7", "opcode 7 ignored", {busy, mem_we, mem_re}, 0);
        cmd_valid = 1'b0;
        idle_check(3, "R7");

        summary();
        $finish;
    end
endmodule